// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

This block is the datapath half of a microprogrammed processor. One shared bus connects all of its storage: a register file that also holds the program counter, an instruction register, a memory address register, two ALU operand latches (A and B), an immediate generator and the memory read port. In every cycle an external sequencer presents a flat control word. That word chooses at most one source to drive the bus and the set of destinations that capture the bus value at the next clock edge. Because every transfer passes over this single bus, an operation such as `rd := rs1 + rs2` takes three control words: load A, load B, then drive the ALU result back into the register file.

The block returns to the sequencer the opcode of the held instruction and a condition flag taken from the ALU result. Toward memory it presents the memory address register as the address, the bus as write data, and read and write strobes. It accepts read data and a busy indication. While a transfer sourced from memory is in progress and busy is high, nothing commits. The sequencer can therefore repeat a "wait" control word until the data is valid.

Top module: `sbus_datapath`

## Requirements
- R1: An active-high synchronous reset clears the program counter, all general registers, the A, B, memory-address and instruction latches to zero.
- R2: `ctrl_i` bits 0..3 enable the bus sources immediate, register file, ALU and memory read data, in that order. The bus is the OR of the enabled sources and is zero when none is enabled. `mem_wdata_o` shows the bus every cycle. `bus_conflict_o` is high in exactly the cycles where two or more of those four bits are set.
- R3: `ctrl_i` bits 6:5 select the register-file entry: 0 = program counter, 1 = the rs1 field (instruction bits 19:15), 2 = the rs2 field (bits 24:20), 3 = the rd field (bits 11:7). When bit 1 is set, the selected entry's current value is on the bus.
- R4: When `ctrl_i` bit 4 is set, the bus value is written into the selected entry at the clock edge. Entry index 0 always reads zero, and writes to it are discarded.
- R5: `ctrl_i` bits 7, 8, 9 and 10 load the A latch, B latch, memory address register and instruction register from the bus at the clock edge. Each holds its value otherwise. `opcode_o` is instruction-register bits 6:0, and `mem_addr_o` is the memory address register.
- R6: `ctrl_i` bits 12:11 select the immediate driven on the bus, sign-extended from instruction bit 31. The formats are: 0 = I {ir[31:20]}; 1 = J {ir[31], ir[19:12], ir[20], ir[30:21], 0}; 2 = B {ir[31], ir[7], ir[30:25], ir[11:8], 0}; 3 = S {ir[31:25], ir[11:7]}.
- R7: `ctrl_i` bits 16:13 select the ALU operation on A and B. The codes are: 0 add, 1 A-B, 2 and, 3 or, 4 xor, 5 signed less-than, 6 unsigned less-than, 7 equal, 8 not-equal, 9 A+4, 10 A-4, 11 pass B, and 12..15 give zero. Comparisons yield 1 or 0.
- R8: `cond_o` is high exactly when the current ALU result is nonzero.
- R9: `mem_re_o` follows `ctrl_i` bit 3, and `mem_we_o` follows `ctrl_i` bit 17. During a write, the address is the memory address register and the data is the bus.
- R10: In a cycle with `ctrl_i` bit 3 set and `mem_busy_i` high, no latch or register-file entry changes. When busy is low, the same control word commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 18 | Flat control word for this cycle |
| mem_rdata_i | input | XLEN | Memory read data |
| mem_busy_i | input | 1 | Memory access still in progress |
| mem_addr_o | output | XLEN | Memory address register |
| mem_wdata_o | output | XLEN | Bus value, used as write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| opcode_o | output | 7 | Opcode field of the instruction register |
| cond_o | output | 1 | ALU result nonzero |
| bus_conflict_o | output | 1 | More than one bus source enabled |

## Verification
The bus, `cond_o`, `bus_conflict_o` and both memory strobes follow the control word combinationally within the same cycle. The bench drives each control word 1 ns after a rising edge and samples these outputs 1 ns later, well before the next edge. Latch and register writes take effect at the next rising edge. The bench checks them in the following cycle, either by driving the stored value back onto the bus or through `mem_addr_o` and `opcode_o`. For the busy stall, the bench holds a memory-sourced word across one edge, confirms that nothing changed, and then lets the same word commit one edge after busy falls.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int CTRL_W = 18;

  typedef enum logic [1:0] {
    SEL_PC  = 2'd0,
    SEL_RS1 = 2'd1,
    SEL_RS2 = 2'd2,
    SEL_RD  = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    IMM_I = 2'd0,
    IMM_J = 2'd1,
    IMM_B = 2'd2,
    IMM_S = 2'd3
  } imm_e;

  typedef enum logic [3:0] {
    ALU_ADD   = 4'd0,
    ALU_SUB   = 4'd1,
    ALU_AND   = 4'd2,
    ALU_OR    = 4'd3,
    ALU_XOR   = 4'd4,
    ALU_SLT   = 4'd5,
    ALU_SLTU  = 4'd6,
    ALU_EQ    = 4'd7,
    ALU_NE    = 4'd8,
    ALU_INC4  = 4'd9,
    ALU_DEC4  = 4'd10,
    ALU_PASSB = 4'd11,
    ALU_R12   = 4'd12,
    ALU_R13   = 4'd13,
    ALU_R14   = 4'd14,
    ALU_R15   = 4'd15
  } alu_op_e;

  // MSB first: bit 17 down to bit 0
  typedef struct packed {
    logic    mem_wr;   // 17
    alu_op_e alu_op;   // 16:13
    imm_e    imm_sel;  // 12:11
    logic    ir_ld;    // 10
    logic    ma_ld;    // 9
    logic    b_ld;     // 8
    logic    a_ld;     // 7
    rsel_e   reg_sel;  // 6:5
    logic    reg_wr;   // 4
    logic    mem_en;   // 3
    logic    alu_en;   // 2
    logic    reg_en;   // 1
    logic    imm_en;   // 0
  } ctrl_t;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            sel_pc_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] rd_vec [NREG];

  always_ff @(posedge clk_i) begin
    if (rst_i)                 pc_q <= '0;
    else if (we_i && sel_pc_i) pc_q <= wdata_i;
  end

  assign rd_vec[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_slot
    logic [XLEN-1:0] q;
    logic            hit;
    assign hit = we_i && !sel_pc_i && (idx_i == IDXW'(g));
    always_ff @(posedge clk_i) begin
      if (rst_i)    q <= '0;
      else if (hit) q <= wdata_i;
    end
    assign rd_vec[g] = q;
  end

  assign rdata_o = sel_pc_i ? pc_q : rd_vec[idx_i];
  assign pc_o    = pc_q;

endmodule

// File: rtl/sbus_immgen.sv
module sbus_immgen
  import sbus_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     ir_i,
  input  imm_e            sel_i,
  output logic [XLEN-1:0] imm_o
);

  function automatic logic [31:0] pick_imm(input logic [31:0] ir, input imm_e s);
    logic [31:0] r;
    unique case (s)
      IMM_I: r = {{20{ir[31]}}, ir[31:20]};
      IMM_J: r = {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
      IMM_B: r = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
      IMM_S: r = {{20{ir[31]}}, ir[31:25], ir[11:7]};
      default: r = '0;
    endcase
    return r;
  endfunction

  logic signed [31:0] imm32;

  assign imm32 = $signed(pick_imm(ir_i, sel_i));
  assign imm_o = XLEN'(imm32);

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o,
  output logic            nz_o
);

  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  function automatic logic [XLEN-1:0] flag(input logic f);
    return XLEN'(f);
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    unique case (op)
      ALU_ADD:   r = a + b;
      ALU_SUB:   r = a - b;
      ALU_AND:   r = a & b;
      ALU_OR:    r = a | b;
      ALU_XOR:   r = a ^ b;
      ALU_SLT:   r = flag($signed(a) < $signed(b));
      ALU_SLTU:  r = flag(a < b);
      ALU_EQ:    r = flag(a == b);
      ALU_NE:    r = flag(a != b);
      ALU_INC4:  r = a + FOUR;
      ALU_DEC4:  r = a - FOUR;
      ALU_PASSB: r = b;
      default:   r = '0;
    endcase
    return r;
  endfunction

  assign y_o  = alu_eval(op_i, a_i, b_i);
  assign nz_o = |y_o;

endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
  parameter int XLEN = 32,
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0]           en_i,
  input  logic [NSRC-1:0][XLEN-1:0] src_i,
  output logic [XLEN-1:0]           bus_o,
  output logic                      conflict_o
);

  logic [NSRC-1:0][XLEN-1:0] gated;

  for (genvar k = 0; k < NSRC; k++) begin : g_drv
    assign gated[k] = en_i[k] ? src_i[k] : '0;
  end

  always_comb begin
    bus_o = '0;
    for (int k = 0; k < NSRC; k++) bus_o = bus_o | gated[k];
  end

  assign conflict_o = ($countones(en_i) > 1);

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_busy_i,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [6:0]        opcode_o,
  output logic              cond_o,
  output logic              bus_conflict_o
);

  ctrl_t c;
  assign c = ctrl_t'(ctrl_i);

  // named internal events
  logic              mem_stall_w;
  logic              commit_w;
  logic [XLEN-1:0]   bus_w;
  logic              conflict_w;
  logic [XLEN-1:0]   imm_w;
  logic [XLEN-1:0]   alu_y_w;
  logic              alu_nz_w;
  logic [XLEN-1:0]   rf_rdata_w;
  logic [XLEN-1:0]   pc_w;
  logic              rf_sel_pc_w;
  logic [IDXW-1:0]   rf_idx_w;
  logic [XLEN-1:0]   a_q, b_q, ma_q;
  logic [31:0]       ir_q;

  assign mem_stall_w = c.mem_en & mem_busy_i;
  assign commit_w    = ~mem_stall_w;

  // register-file index from instruction fields
  always_comb begin
    unique case (c.reg_sel)
      SEL_RS1: rf_idx_w = ir_q[15 +: IDXW];
      SEL_RS2: rf_idx_w = ir_q[20 +: IDXW];
      SEL_RD:  rf_idx_w = ir_q[7 +: IDXW];
      default: rf_idx_w = '0;
    endcase
  end
  assign rf_sel_pc_w = (c.reg_sel == SEL_PC);

  sbus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sel_pc_i(rf_sel_pc_w),
    .idx_i   (rf_idx_w),
    .we_i    (c.reg_wr & commit_w),
    .wdata_i (bus_w),
    .rdata_o (rf_rdata_w),
    .pc_o    (pc_w)
  );

  sbus_immgen #(.XLEN(XLEN)) u_imm (
    .ir_i (ir_q),
    .sel_i(c.imm_sel),
    .imm_o(imm_w)
  );

  sbus_alu #(.XLEN(XLEN)) u_alu (
    .op_i(c.alu_op),
    .a_i (a_q),
    .b_i (b_q),
    .y_o (alu_y_w),
    .nz_o(alu_nz_w)
  );

  sbus_bus #(.XLEN(XLEN), .NSRC(4)) u_bus (
    .en_i      ({c.mem_en, c.alu_en, c.reg_en, c.imm_en}),
    .src_i     ({mem_rdata_i, alu_y_w, rf_rdata_w, imm_w}),
    .bus_o     (bus_w),
    .conflict_o(conflict_w)
  );

  // bus-loaded latches
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
      ir_q <= '0;
    end else if (commit_w) begin
      if (c.a_ld)  a_q  <= bus_w;
      if (c.b_ld)  b_q  <= bus_w;
      if (c.ma_ld) ma_q <= bus_w;
      if (c.ir_ld) ir_q <= bus_w[31:0];
    end
  end

  assign mem_addr_o     = ma_q;
  assign mem_wdata_o    = bus_w;
  assign mem_we_o       = c.mem_wr;
  assign mem_re_o       = c.mem_en;
  assign opcode_o       = ir_q[6:0];
  assign cond_o         = alu_nz_w;
  assign bus_conflict_o = conflict_w;

endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int XLEN = 32,
  parameter int IDXW = 5
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic [17:0]     ctrl_i,
  input logic            mem_busy_i,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            bus_conflict_o,
  input logic [XLEN-1:0] pc_w,
  input logic [XLEN-1:0] rf_rdata_w,
  input logic            rf_sel_pc_w,
  input logic [IDXW-1:0] rf_idx_w,
  input logic [31:0]     ir_q
);

  AST_PC_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> pc_w == '0); // R1

  AST_CONFLICT_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_conflict_o == !$onehot0(ctrl_i[3:0])); // R2

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i[3:0] == 4'b0) |-> mem_wdata_o == '0); // R2

  AST_X0_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rf_sel_pc_w && rf_idx_w == '0) |-> rf_rdata_w == '0); // R4

  AST_MA_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i[9] && !(ctrl_i[3] && mem_busy_i)) |=> mem_addr_o == $past(mem_wdata_o)); // R5

  AST_MA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl_i[9] |=> $stable(mem_addr_o)); // R5

  AST_BUSY_FREEZES_IR: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i[3] && mem_busy_i) |=> $stable(ir_q)); // R10

  AST_BUSY_FREEZES_PC: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i[3] && mem_busy_i) |=> $stable(pc_w)); // R10

endmodule

bind sbus_datapath sbus_datapath_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .ctrl_i        (ctrl_i),
  .mem_busy_i    (mem_busy_i),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .bus_conflict_o(bus_conflict_o),
  .pc_w          (pc_w),
  .rf_rdata_w    (rf_rdata_w),
  .rf_sel_pc_w   (rf_sel_pc_w),
  .rf_idx_w      (rf_idx_w),
  .ir_q          (ir_q)
);

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [17:0]     ctrl;
  logic [XLEN-1:0] mrdata;
  logic            mbusy;
  logic [XLEN-1:0] maddr, mwdata;
  logic            mwe, mre, cond, confl;
  logic [6:0]      opc;

  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  sbus_datapath #(.XLEN(XLEN), .NREG(32)) u0 (
    .clk_i(clk), .rst_i(rst), .ctrl_i(ctrl),
    .mem_rdata_i(mrdata), .mem_busy_i(mbusy),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_we_o(mwe), .mem_re_o(mre), .opcode_o(opc),
    .cond_o(cond), .bus_conflict_o(confl)
  );

  // control word fields, per the requirements
  localparam logic [17:0] IMM_EN = 18'h00001;
  localparam logic [17:0] REG_EN = 18'h00002;
  localparam logic [17:0] ALU_EN = 18'h00004;
  localparam logic [17:0] MEM_EN = 18'h00008;
  localparam logic [17:0] REG_WR = 18'h00010;
  localparam logic [17:0] A_LD   = 18'h00080;
  localparam logic [17:0] B_LD   = 18'h00100;
  localparam logic [17:0] MA_LD  = 18'h00200;
  localparam logic [17:0] IR_LD  = 18'h00400;
  localparam logic [17:0] MEM_WR = 18'h20000;

  function automatic logic [17:0] rsel(input int s); return 18'(s) << 5;  endfunction
  function automatic logic [17:0] isel(input int s); return 18'(s) << 11; endfunction
  function automatic logic [17:0] aop(input int o);  return 18'(o) << 13; endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic apply(input logic [17:0] c);
    ctrl = c;
    #1;
  endtask

  task automatic edge_();
    @(posedge clk);
    #1;
  endtask

  // bench immediate model, built bit by bit
  function automatic logic [31:0] exp_imm(input logic [31:0] ir, input int s);
    logic [31:0] v = '0;
    int top;
    if (s == 0) begin v[11:0] = ir[31:20]; top = 11; end
    else if (s == 1) begin
      v[20] = ir[31]; v[19:12] = ir[19:12]; v[11] = ir[20]; v[10:1] = ir[30:21]; top = 20;
    end else if (s == 2) begin
      v[12] = ir[31]; v[11] = ir[7]; v[10:5] = ir[30:25]; v[4:1] = ir[11:8]; top = 12;
    end else begin v[11:5] = ir[31:25]; v[4:0] = ir[11:7]; top = 11; end
    for (int i = top + 1; i < 32; i++) v[i] = v[top];
    return v;
  endfunction

  function automatic logic [31:0] exp_alu(input int op, input logic [31:0] a, input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    if (op == 0) return a + b;
    if (op == 1) return a + ~b + 32'd1;
    if (op == 2) return a & b;
    if (op == 3) return a | b;
    if (op == 4) return a ^ b;
    if (op == 5) return (sa < sb) ? 32'd1 : 32'd0;
    if (op == 6) return ({1'b0, a} < {1'b0, b}) ? 32'd1 : 32'd0;
    if (op == 7) return (a == b) ? 32'd1 : 32'd0;
    if (op == 8) return (a == b) ? 32'd0 : 32'd1;
    if (op == 9) return a + 32'd4;
    if (op == 10) return a - 32'd4;
    if (op == 11) return b;
    return 32'd0;
  endfunction

  task automatic fetch(input logic [31:0] instr, input logic [6:0] old_opc);
    mbusy = 1'b1; mrdata = 32'hDEAD_BEEF;
    apply(MEM_EN | IR_LD);
    chk("R9 read strobe", {31'b0, mre}, 32'd1);
    edge_();
    chk("R10 IR held while busy", {25'b0, opc}, {25'b0, old_opc});
    mbusy = 1'b0; mrdata = instr;
    apply(MEM_EN | IR_LD);
    edge_();
    chk("R5 opcode after load", {25'b0, opc}, {25'b0, instr[6:0]});
    apply('0);
  endtask

  task automatic t_reset();
    apply(REG_EN | rsel(0));
    chk("R1 pc zero", mwdata, 32'd0);
    apply(REG_EN | rsel(3));
    chk("R1 reg zero", mwdata, 32'd0);
    chk("R1 MA zero", maddr, 32'd0);
    chk("R1 IR zero", {25'b0, opc}, 32'd0);
    apply(ALU_EN | aop(11));
    chk("R1 B zero", mwdata, 32'd0);
    apply('0);
    chk("R2 idle bus", mwdata, 32'd0);
    chk("R2 no conflict", {31'b0, confl}, 32'd0);
  endtask

  localparam logic [31:0] INS1 = {12'hFFD, 5'd2, 3'b000, 5'd5, 7'h13};
  localparam logic [31:0] INS2 = {7'h00, 5'd5, 5'd5, 3'b000, 5'd0, 7'h33};
  localparam logic [31:0] INS3 = 32'hA5C3_E6F3;

  task automatic t_regwrite();
    fetch(INS1, 7'h00);
    apply(IMM_EN | isel(0) | rsel(3) | REG_WR);
    chk("R6 I imm on bus", mwdata, 32'hFFFF_FFFD);
    edge_();
    apply(REG_EN | rsel(3));
    chk("R4 rd written", mwdata, 32'hFFFF_FFFD);
    apply(REG_EN | rsel(1));
    chk("R3 rs1 untouched", mwdata, 32'd0);
  endtask

  task automatic t_x0();
    fetch(INS2, 7'h13);
    apply(IMM_EN | isel(0) | rsel(3) | REG_WR);
    edge_();
    apply(REG_EN | rsel(3));
    chk("R4 x0 reads zero", mwdata, 32'd0);
    apply(REG_EN | rsel(1));
    chk("R3 rs1 select", mwdata, 32'hFFFF_FFFD);
    apply(REG_EN | rsel(2));
    chk("R3 rs2 select", mwdata, 32'hFFFF_FFFD);
  endtask

  task automatic t_alu();
    logic [31:0] a = 32'hFFFF_FFFD;
    logic [31:0] b = 32'd5;
    logic [31:0] e;
    apply(REG_EN | rsel(1) | A_LD);
    edge_();
    apply(IMM_EN | isel(0) | B_LD);
    edge_();
    for (int op = 0; op < 16; op++) begin
      apply(ALU_EN | aop(op));
      e = exp_alu(op, a, b);
      chk($sformatf("R7 alu op %0d", op), mwdata, e);
      chk($sformatf("R8 cond op %0d", op), {31'b0, cond}, {31'b0, (e != 0)});
    end
    apply('0);
  endtask

  task automatic t_pc();
    for (int k = 1; k <= 2; k++) begin
      apply(REG_EN | rsel(0) | MA_LD | A_LD);
      edge_();
      chk("R5 MA from pc", maddr, 32'(4 * (k - 1)));
      apply(ALU_EN | aop(9) | rsel(0) | REG_WR);
      edge_();
      apply(REG_EN | rsel(0));
      chk("R3 pc advanced", mwdata, 32'(4 * k));
    end
    apply(IMM_EN | isel(0));
    edge_();
    chk("R5 MA holds", maddr, 32'd4);
  endtask

  task automatic t_imm();
    fetch(INS3, 7'h33);
    for (int s = 0; s < 4; s++) begin
      apply(IMM_EN | isel(s));
      chk($sformatf("R6 imm fmt %0d", s), mwdata, exp_imm(INS3, s));
    end
  endtask

  task automatic t_memwrite();
    apply(IMM_EN | isel(0) | rsel(3) | REG_WR);
    edge_();
    apply(IMM_EN | isel(3) | MA_LD);
    edge_();
    apply(REG_EN | rsel(3) | MEM_WR);
    chk("R9 write strobe", {31'b0, mwe}, 32'd1);
    chk("R9 write addr", maddr, exp_imm(INS3, 3));
    chk("R9 write data", mwdata, exp_imm(INS3, 0));
    chk("R9 no read strobe", {31'b0, mre}, 32'd0);
    apply('0);
    chk("R9 strobe off", {31'b0, mwe}, 32'd0);
  endtask

  task automatic t_conflict();
    apply(IMM_EN | REG_EN);
    chk("R2 conflict imm+reg", {31'b0, confl}, 32'd1);
    apply(ALU_EN);
    chk("R2 single source", {31'b0, confl}, 32'd0);
    mrdata = 32'h0;
    apply(MEM_EN | ALU_EN | REG_EN);
    chk("R2 conflict three", {31'b0, confl}, 32'd1);
    apply('0);
  endtask

  task automatic t_busy();
    mbusy = 1'b1; mrdata = 32'h1234;
    apply(MEM_EN | rsel(0) | REG_WR | A_LD);
    edge_();
    mbusy = 1'b0;
    apply(REG_EN | rsel(0));
    chk("R10 pc unchanged while busy", mwdata, 32'd8);
    mrdata = 32'h40;
    apply(MEM_EN | rsel(0) | REG_WR);
    edge_();
    apply(REG_EN | rsel(0));
    chk("R10 pc written when ready", mwdata, 32'h40);
    apply('0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; ctrl = '0; mrdata = '0; mbusy = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_regwrite();
    t_x0();
    t_alu();
    t_pc();
    t_imm();
    t_memwrite();
    t_conflict();
    t_busy();
    finish_run();
  end

endmodule